// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block runs the memory side of a subroutine call and a subroutine return for a small 32-bit processor. The core pulses `start` with an operation code and the current program counter, frame pointer and stack pointer. The sequencer then builds or removes a three-word stack frame through a word-wide memory port that uses a request/acknowledge handshake. When the sequence is finished it presents the new program counter, frame pointer and stack pointer, together with a one-cycle `done` pulse. The register file and the instruction decoder sit outside the block. They take the results when `done` is high.

A call first reserves one empty word below the stack pointer for a static-chain link, which is never written. It then pushes the return address and the caller's frame pointer, and both pointers end up on the last pushed word. A return walks upward from the frame pointer, not from the stack pointer. It pops the saved frame pointer and the return address, then steps over the static-chain word. A software interrupt records a cause code and the interrupt number on a special-register write port. The reserved number `0xFFFFFFFF` additionally enters a handler through the same frame push.

Top module: `csq_frame_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, `done`, `mem_req` and `sreg_we` are low and `new_pc`, `new_fp` and `new_sp` are zero.
- R2: For a call (op 0 or op 1), the first memory access is a write of the return address to `cur_sp - 8`, and the second is a write of the old `cur_fp` to `cur_sp - 12`. The static-chain word at `cur_sp - 4` is never accessed.
- R3: The return address is `cur_pc + 6` for the absolute call (op 0) and `cur_pc + 2` for the register call (op 1).
- R4: When a call completes, `new_pc` equals the captured `target`, and both `new_fp` and `new_sp` equal `cur_sp - 12` (modulo 2^32).
- R5: A return (op 2) reads the word at `cur_fp` and then the word at `cur_fp + 4`. It completes with `new_fp` set to the first word read, `new_pc` set to the second, and `new_sp` set to `cur_fp + 12`.
- R6: A software interrupt (op 3) writes special register 2 with the value 3. In the next cycle it writes special register 3 with `swi_num`. For any other number than `0xFFFFFFFF` it makes no memory access, and it completes with `new_pc = cur_pc + 6` and with `new_fp` and `new_sp` unchanged from the inputs.
- R7: A software interrupt whose number is `0xFFFFFFFF` follows the two special-register writes with the call frame push of R2. The return address is `cur_pc + 6`, and the new program counter is `swi_handler`.
- R8: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until a cycle with `mem_ack` high. A memory request and a special-register write never occur in the same cycle.
- R9: `done` is high for exactly one cycle per sequence. `new_pc`, `new_fp` and `new_sp` change only in a cycle where `done` is high, and they hold the results in that cycle.
- R10: A `start` pulse that arrives while a sequence is in progress is ignored. It causes no memory access, no special-register write and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op | input | 2 | 0 absolute call, 1 register call, 2 return, 3 software interrupt |
| target | input | 32 | Call destination |
| cur_pc | input | 32 | Address of the call or interrupt instruction |
| cur_fp | input | 32 | Current frame pointer |
| cur_sp | input | 32 | Current stack pointer |
| swi_num | input | 32 | Software interrupt number |
| swi_handler | input | 32 | Handler address used for the frame-entering interrupt number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| sreg_we | output | 1 | Special-register write strobe |
| sreg_idx | output | SREG_IDX_W (8) | Special-register index |
| sreg_wdata | output | 32 | Special-register write data |
| new_pc | output | 32 | Resulting program counter |
| new_fp | output | 32 | Resulting frame pointer |
| new_sp | output | 32 | Resulting stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the sequencer with its default parameters: an 8-bit special-register index, cause index 2, number index 3 and cause value 3. These are the values the requirements state, so every expected special-register write follows directly from them. The memory model in the bench varies its acknowledge latency between zero and three cycles, which stretches the request-hold window and leaves room to land a second `start` in the middle of a frame push. Stack pointers near address zero exercise the wraparound of the frame arithmetic. A call followed by a return through the pushed frame shows that the original stack pointer and frame pointer are restored.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int XLEN       = 32;
    localparam int WORD_BYTES = XLEN / 8;

    typedef logic [XLEN-1:0] word_t;

    localparam word_t STEP          = word_t'(WORD_BYTES);
    localparam word_t LONG_INSN_LEN = word_t'(6);
    localparam word_t SHORT_INSN_LEN = word_t'(2);
    localparam word_t FRAME_SWI_NUM = '1;

    typedef enum logic [1:0] {
        OP_CALL_ABS = 2'd0,
        OP_CALL_REG = 2'd1,
        OP_RETURN   = 2'd2,
        OP_SWI      = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR_CAUSE,
        ST_SR_NUM,
        ST_PUSH_RA,
        ST_PUSH_FP,
        ST_POP_FP,
        ST_POP_RA
    } st_e;

    typedef struct packed {
        op_e   op;
        word_t target;
        word_t ret_addr;
        word_t fp;
        word_t sp;
        word_t swi_num;
    } cmd_t;

    typedef struct packed {
        logic  fire;
        word_t pc;
        word_t fp;
        word_t sp;
    } result_t;

    function automatic word_t link_addr(op_e op, word_t pc);
        return (op == OP_CALL_REG) ? pc + SHORT_INSN_LEN : pc + LONG_INSN_LEN;
    endfunction

    function automatic logic is_call(op_e op);
        return (op == OP_CALL_ABS) || (op == OP_CALL_REG);
    endfunction

endpackage

// File: rtl/csq_cmd_reg.sv
module csq_cmd_reg
    import csq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  op_e   op,
    input  word_t target,
    input  word_t pc,
    input  word_t fp,
    input  word_t sp,
    input  word_t swi_num,
    input  word_t swi_handler,
    output cmd_t  cmd
);

    cmd_t cmd_d;

    always_comb begin
        cmd_d.op       = op;
        cmd_d.target   = (op == OP_SWI) ? swi_handler : target;
        cmd_d.ret_addr = link_addr(op, pc);
        cmd_d.fp       = fp;
        cmd_d.sp       = sp;
        cmd_d.swi_num  = swi_num;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (accept) begin
            cmd <= cmd_d;
        end
    end

endmodule

// File: rtl/csq_seq.sv
module csq_seq
    import csq_pkg::*;
#(
    parameter int    SREG_IDX_W = 8,
    parameter int    CAUSE_IDX  = 2,
    parameter int    NUM_IDX    = 3,
    parameter word_t CAUSE_VAL  = 3
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  op_e                   start_op,
    input  word_t                 start_fp,
    input  word_t                 start_sp,
    input  cmd_t                  cmd,
    input  logic                  mem_ack,
    input  word_t                 mem_rdata,
    output logic                  accept,
    output logic                  mem_req,
    output logic                  mem_we,
    output word_t                 mem_addr,
    output word_t                 mem_wdata,
    output logic                  sreg_we,
    output logic [SREG_IDX_W-1:0] sreg_idx,
    output word_t                 sreg_wdata,
    output result_t               res
);

    localparam logic [SREG_IDX_W-1:0] CAUSE_SEL = SREG_IDX_W'(CAUSE_IDX);
    localparam logic [SREG_IDX_W-1:0] NUM_SEL   = SREG_IDX_W'(NUM_IDX);

    st_e   state_q;
    word_t wptr_q;
    word_t popped_fp_q;
    logic  enter_frame;

    assign accept      = start && (state_q == ST_IDLE);
    assign enter_frame = (cmd.swi_num == FRAME_SWI_NUM);

    // Sequencing. For pushes the pointer sits one word above the next slot,
    // for pops it sits on the word being read.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            wptr_q      <= '0;
            popped_fp_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (is_call(start_op)) begin
                            wptr_q  <= start_sp - STEP;
                            state_q <= ST_PUSH_RA;
                        end else if (start_op == OP_RETURN) begin
                            wptr_q  <= start_fp;
                            state_q <= ST_POP_FP;
                        end else begin
                            state_q <= ST_SR_CAUSE;
                        end
                    end
                end
                ST_SR_CAUSE: state_q <= ST_SR_NUM;
                ST_SR_NUM: begin
                    if (enter_frame) begin
                        wptr_q  <= cmd.sp - STEP;
                        state_q <= ST_PUSH_RA;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_PUSH_RA: begin
                    if (mem_ack) begin
                        wptr_q  <= wptr_q - STEP;
                        state_q <= ST_PUSH_FP;
                    end
                end
                ST_PUSH_FP: begin
                    if (mem_ack) begin
                        wptr_q  <= wptr_q - STEP;
                        state_q <= ST_IDLE;
                    end
                end
                ST_POP_FP: begin
                    if (mem_ack) begin
                        popped_fp_q <= mem_rdata;
                        wptr_q      <= wptr_q + STEP;
                        state_q     <= ST_POP_RA;
                    end
                end
                ST_POP_RA: begin
                    if (mem_ack) begin
                        wptr_q  <= wptr_q + STEP;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory request, held steady by the state until acknowledged.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wptr_q;
        mem_wdata = '0;
        unique case (state_q)
            ST_PUSH_RA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr_q - STEP;
                mem_wdata = cmd.ret_addr;
            end
            ST_PUSH_FP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr_q - STEP;
                mem_wdata = cmd.fp;
            end
            ST_POP_FP, ST_POP_RA: begin
                mem_req  = 1'b1;
                mem_addr = wptr_q;
            end
            default: ;
        endcase
    end

    // Special-register write port.
    always_comb begin
        sreg_we    = 1'b0;
        sreg_idx   = '0;
        sreg_wdata = '0;
        if (state_q == ST_SR_CAUSE) begin
            sreg_we    = 1'b1;
            sreg_idx   = CAUSE_SEL;
            sreg_wdata = CAUSE_VAL;
        end else if (state_q == ST_SR_NUM) begin
            sreg_we    = 1'b1;
            sreg_idx   = NUM_SEL;
            sreg_wdata = cmd.swi_num;
        end
    end

    // Completion values handed to the result registers.
    always_comb begin
        res = '0;
        if (state_q == ST_PUSH_FP && mem_ack) begin
            res.fire = 1'b1;
            res.pc   = cmd.target;
            res.fp   = wptr_q - STEP;
            res.sp   = wptr_q - STEP;
        end else if (state_q == ST_POP_RA && mem_ack) begin
            res.fire = 1'b1;
            res.pc   = mem_rdata;
            res.fp   = popped_fp_q;
            res.sp   = wptr_q + STEP + STEP;
        end else if (state_q == ST_SR_NUM && !enter_frame) begin
            res.fire = 1'b1;
            res.pc   = cmd.ret_addr;
            res.fp   = cmd.fp;
            res.sp   = cmd.sp;
        end
    end

endmodule

// File: rtl/csq_result.sv
module csq_result
    import csq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  result_t res,
    output word_t   new_pc,
    output word_t   new_fp,
    output word_t   new_sp,
    output logic    done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            new_pc <= '0;
            new_fp <= '0;
            new_sp <= '0;
            done   <= 1'b0;
        end else begin
            done <= res.fire;
            if (res.fire) begin
                new_pc <= res.pc;
                new_fp <= res.fp;
                new_sp <= res.sp;
            end
        end
    end

endmodule

// File: rtl/csq_frame_seq.sv
module csq_frame_seq
    import csq_pkg::*;
#(
    parameter int    SREG_IDX_W = 8,
    parameter int    CAUSE_IDX  = 2,
    parameter int    NUM_IDX    = 3,
    parameter word_t CAUSE_VAL  = 3
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            op,
    input  logic [XLEN-1:0]       target,
    input  logic [XLEN-1:0]       cur_pc,
    input  logic [XLEN-1:0]       cur_fp,
    input  logic [XLEN-1:0]       cur_sp,
    input  logic [XLEN-1:0]       swi_num,
    input  logic [XLEN-1:0]       swi_handler,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [XLEN-1:0]       mem_wdata,
    input  logic [XLEN-1:0]       mem_rdata,
    input  logic                  mem_ack,
    output logic                  sreg_we,
    output logic [SREG_IDX_W-1:0] sreg_idx,
    output logic [XLEN-1:0]       sreg_wdata,
    output logic [XLEN-1:0]       new_pc,
    output logic [XLEN-1:0]       new_fp,
    output logic [XLEN-1:0]       new_sp,
    output logic                  done
);

    op_e     op_in;
    logic    accept;
    cmd_t    cmd;
    result_t res;

    assign op_in = op_e'(op);

    csq_cmd_reg u_cmd (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .op          (op_in),
        .target      (target),
        .pc          (cur_pc),
        .fp          (cur_fp),
        .sp          (cur_sp),
        .swi_num     (swi_num),
        .swi_handler (swi_handler),
        .cmd         (cmd)
    );

    csq_seq #(
        .SREG_IDX_W (SREG_IDX_W),
        .CAUSE_IDX  (CAUSE_IDX),
        .NUM_IDX    (NUM_IDX),
        .CAUSE_VAL  (CAUSE_VAL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_op   (op_in),
        .start_fp   (cur_fp),
        .start_sp   (cur_sp),
        .cmd        (cmd),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .accept     (accept),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sreg_we    (sreg_we),
        .sreg_idx   (sreg_idx),
        .sreg_wdata (sreg_wdata),
        .res        (res)
    );

    csq_result u_res (
        .clk    (clk),
        .rst    (rst),
        .res    (res),
        .new_pc (new_pc),
        .new_fp (new_fp),
        .new_sp (new_sp),
        .done   (done)
    );

endmodule

// File: rtl/csq_checker.sv
module csq_checker
    import csq_pkg::*;
#(
    parameter int SREG_IDX_W = 8,
    parameter int CAUSE_IDX  = 2,
    parameter int NUM_IDX    = 3
)(
    input logic                  clk,
    input logic                  rst,
    input logic                  mem_req,
    input logic                  mem_we,
    input logic [XLEN-1:0]       mem_addr,
    input logic [XLEN-1:0]       mem_wdata,
    input logic                  mem_ack,
    input logic                  sreg_we,
    input logic [SREG_IDX_W-1:0] sreg_idx,
    input logic [XLEN-1:0]       new_pc,
    input logic [XLEN-1:0]       new_fp,
    input logic [XLEN-1:0]       new_sp,
    input logic                  done
);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r8_one_channel: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && sreg_we));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_results_on_done: assert property (@(posedge clk) disable iff (rst)
        ((new_pc != $past(new_pc)) || (new_fp != $past(new_fp)) || (new_sp != $past(new_sp))) |-> done);

    a_r6_sreg_pair: assert property (@(posedge clk) disable iff (rst)
        (sreg_we && sreg_idx == SREG_IDX_W'(CAUSE_IDX)) |=> (sreg_we && sreg_idx == SREG_IDX_W'(NUM_IDX)));

endmodule

bind csq_frame_seq csq_checker #(
    .SREG_IDX_W (SREG_IDX_W),
    .CAUSE_IDX  (CAUSE_IDX),
    .NUM_IDX    (NUM_IDX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .sreg_we   (sreg_we),
    .sreg_idx  (sreg_idx),
    .new_pc    (new_pc),
    .new_fp    (new_fp),
    .new_sp    (new_sp),
    .done      (done)
);

// File: tb/csq_frame_seq_tb_top.sv
module csq_frame_seq_tb_top;
    import csq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    word_t       target = '0, cur_pc = '0, cur_fp = '0, cur_sp = '0;
    word_t       swi_num = '0, swi_handler = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    word_t       mem_addr, mem_wdata, mem_rdata = '0;
    logic        sreg_we;
    logic [7:0]  sreg_idx;
    word_t       sreg_wdata, new_pc, new_fp, new_sp;
    logic        done;

    csq_frame_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .target(target),
        .cur_pc(cur_pc), .cur_fp(cur_fp), .cur_sp(cur_sp),
        .swi_num(swi_num), .swi_handler(swi_handler),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .sreg_we(sreg_we), .sreg_idx(sreg_idx), .sreg_wdata(sreg_wdata),
        .new_pc(new_pc), .new_fp(new_fp), .new_sp(new_sp), .done(done)
    );

    typedef struct packed { logic we; word_t addr; word_t data; } mtx_t;
    typedef struct packed { logic [7:0] idx; word_t data; } stx_t;
    typedef struct packed { word_t pc; word_t fp; word_t sp; } rtx_t;

    mtx_t  exp_mem[$];
    string mem_tag[$];
    stx_t  exp_sreg[$];
    rtx_t  exp_res[$];
    string res_tag[$];

    word_t memory [word_t];
    int    vectors = 0;
    int    errors  = 0;
    int    lat     = 0;
    int    done_count = 0;
    bit    finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input word_t act, input word_t exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory responder: compares each access against the scoreboard.
    initial begin
        int    wait_cnt = 0;
        word_t hold_addr = '0;
        mtx_t  e;
        string t;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && !rst) begin
                if (wait_cnt == 0) hold_addr = mem_addr;
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    if (lat > 0) chk(mem_addr == hold_addr, "R8", "address held", mem_addr, hold_addr);
                    if (exp_mem.size() == 0) begin
                        chk(1'b0, "R10", "unexpected memory access", mem_addr, '0);
                    end else begin
                        e = exp_mem.pop_front();
                        t = mem_tag.pop_front();
                        chk(mem_we == e.we, t, "access direction", word_t'(mem_we), word_t'(e.we));
                        chk(mem_addr == e.addr, t, "access address", mem_addr, e.addr);
                        if (e.we) chk(mem_wdata == e.data, t, "write data", mem_wdata, e.data);
                    end
                    if (mem_we) memory[mem_addr] = mem_wdata;
                    else mem_rdata = memory.exists(mem_addr) ? memory[mem_addr] : '0;
                    mem_ack  = 1'b1;
                    wait_cnt = 0;
                end
            end
        end
    end

    // Special-register monitor.
    initial begin
        stx_t e;
        bit   prev_cause = 0;
        forever begin
            @(negedge clk);
            if (sreg_we && !rst) begin
                if (sreg_idx == 8'd3) chk(prev_cause, "R6", "number write follows cause write", word_t'(prev_cause), 1);
                if (exp_sreg.size() == 0) begin
                    chk(1'b0, "R10", "unexpected special-register write", word_t'(sreg_idx), '0);
                end else begin
                    e = exp_sreg.pop_front();
                    chk(sreg_idx == e.idx, "R6", "special-register index", word_t'(sreg_idx), word_t'(e.idx));
                    chk(sreg_wdata == e.data, "R6", "special-register data", sreg_wdata, e.data);
                end
            end
            prev_cause = sreg_we && (sreg_idx == 8'd2);
        end
    end

    // Result monitor.
    initial begin
        rtx_t e;
        string t;
        bit prev_done = 0;
        forever begin
            @(negedge clk);
            if (done && prev_done) chk(1'b0, "R9", "done longer than one cycle", 1, 0);
            if (done && !rst) begin
                done_count++;
                if (exp_res.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", new_pc, '0);
                end else begin
                    e = exp_res.pop_front();
                    t = res_tag.pop_front();
                    chk(new_pc == e.pc, t, "new_pc", new_pc, e.pc);
                    chk(new_fp == e.fp, t, "new_fp", new_fp, e.fp);
                    chk(new_sp == e.sp, t, "new_sp", new_sp, e.sp);
                end
            end
            prev_done = done;
        end
    end

    task automatic push_frame(input word_t ra, input word_t tgt, input word_t fp,
                              input word_t sp, input string tag);
        exp_mem.push_back('{1'b1, sp - 32'd8, ra});  mem_tag.push_back("R2");
        exp_mem.push_back('{1'b1, sp - 32'd12, fp}); mem_tag.push_back("R2");
        exp_res.push_back('{tgt, sp - 32'd12, sp - 32'd12}); res_tag.push_back(tag);
    endtask

    task automatic run(input logic [1:0] o, input word_t tgt, input word_t pc,
                       input word_t fp, input word_t sp, input word_t num,
                       input word_t hnd, input int latency, input bit extra);
        int want;
        lat  = latency;
        want = done_count + 1;
        case (o)
            2'd0: push_frame(pc + 32'd6, tgt, fp, sp, "R3 R4");
            2'd1: push_frame(pc + 32'd2, tgt, fp, sp, "R3 R4");
            2'd2: begin
                exp_mem.push_back('{1'b0, fp, '0});         mem_tag.push_back("R5");
                exp_mem.push_back('{1'b0, fp + 32'd4, '0}); mem_tag.push_back("R5");
                exp_res.push_back('{memory[fp + 32'd4], memory[fp], fp + 32'd12});
                res_tag.push_back("R5");
            end
            default: begin
                exp_sreg.push_back('{8'd2, 32'd3});
                exp_sreg.push_back('{8'd3, num});
                if (num == 32'hFFFF_FFFF) push_frame(pc + 32'd6, hnd, fp, sp, "R7");
                else begin
                    exp_res.push_back('{pc + 32'd6, fp, sp});
                    res_tag.push_back("R6");
                end
            end
        endcase
        @(negedge clk);
        op = o; target = tgt; cur_pc = pc; cur_fp = fp; cur_sp = sp;
        swi_num = num; swi_handler = hnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op = 2'd2; target = 32'h5A5A_5A5A; cur_pc = ~pc; cur_fp = 32'h1000;
        cur_sp = 32'h2000; swi_num = 32'd9; swi_handler = 32'h0BAD_0BAD;
        if (extra) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_count < want) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", word_t'(done), 0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", word_t'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0 && sreg_we == 1'b0, "R1", "strobes after reset",
            word_t'({done, mem_req, sreg_we}), 0);
        chk(new_pc == '0 && new_fp == '0 && new_sp == '0, "R1", "results after reset",
            new_pc | new_fp | new_sp, 0);

        // R2: static-chain word must stay untouched
        memory[32'h7FEC] = 32'hDEAD_BEEF;
        run(2'd0, 32'h2000, 32'h100, 32'h8000, 32'h7FF0, 0, 0, 0, 0);
        chk(memory[32'h7FEC] == 32'hDEAD_BEEF, "R2", "static-chain slot untouched",
            memory[32'h7FEC], 32'hDEAD_BEEF);
        run(2'd1, 32'h3000, 32'h204, 32'h7000, 32'h6F00, 0, 0, 2, 0);

        // R5: plain return from a prepared frame
        memory[32'h9000] = 32'h1111_2222;
        memory[32'h9004] = 32'h0000_0400;
        run(2'd2, 0, 0, 32'h9000, 32'h1234, 0, 0, 1, 0);

        // R5: call then return through the pushed frame restores pointers
        run(2'd0, 32'h4400, 32'h500, 32'h6100, 32'h6000, 0, 0, 1, 0);
        run(2'd2, 0, 0, 32'h5FF4, 32'h5FF4, 0, 0, 0, 0);
        chk(new_sp == 32'h6000, "R5", "stack pointer restored", new_sp, 32'h6000);
        chk(new_fp == 32'h6100, "R5", "frame pointer restored", new_fp, 32'h6100);
        chk(new_pc == 32'h506, "R5", "return lands after call", new_pc, 32'h506);

        run(2'd3, 0, 32'h700, 32'h3300, 32'h3200, 32'h5, 32'hA000, 0, 0);
        run(2'd3, 0, 32'h800, 32'h4010, 32'h4000, 32'hFFFF_FFFF, 32'hA000, 3, 0);

        // R10: second start during a busy push
        run(2'd0, 32'hC000, 32'h900, 32'h2200, 32'h2100, 0, 0, 2, 1);
        run(2'd1, 32'hD000, 32'hA00, 32'h0, 32'h8, 0, 0, 0, 0);
        run(2'd3, 0, 32'hB00, 32'h50, 32'h60, 32'h0, 32'h0, 1, 1);

        repeat (6) @(negedge clk);
        chk(exp_mem.size() == 0, "R10", "pending memory items", exp_mem.size(), 0);
        chk(exp_res.size() == 0, "R10", "pending results", exp_res.size(), 0);
        chk(exp_sreg.size() == 0, "R6", "pending special-register items", exp_sreg.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule